// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This controller sits next to a small 8-bit processor core and decides when the core may leave its program to serve an interrupt. It collects twenty direct request flags and five serial-port events. It qualifies each one with its own enable bit, where the source has one. It then applies one of two mask bits that it holds for the core's condition code register. These are a general mask bit (I) and a one-way mask bit (X), which guards the non-maskable pin. Source index 0 has the highest priority. Each source index maps to a 16-bit vector address, counting down two bytes at a time from 0xFFFE.

An interrupt can only start at an instruction boundary. The core marks each boundary with `insn_done`. If any source is eligible at that boundary, the controller latches the winning source. It then steps the core through nine register pushes, one per cycle, and presents the vector for one cycle. The core marks a return-from-interrupt by raising `rti_req` together with `insn_done`. For that case the controller steps through the same nine registers in reverse order as pulls. The core reloads the mask bits through the CCR write port. That port lets software write I freely and only ever set X.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, mask_i is 1 and mask_x is 0. The outputs take, busy, stk_push, stk_pull and vec_valid are all 0.
- R2: The following sources have a local enable and are only eligible while their src_en bit is 1: index 1 and indices 7 to 19. Sources 0, 2, 3, 4, 5 and 6 ignore src_en. Sources 0 to 4 are never masked. Source 5 is masked while mask_x is 1. Sources 6 to 20 are masked while mask_i is 1. irq_pend is 1 exactly when some source is eligible.
- R3: No interrupt starts unless insn_done is high while the controller is idle. When it is high in an idle cycle with a source eligible, take is 1 in the next cycle, for exactly one cycle.
- R4: The push run starts in the same cycle as take. stk_push is high for nine consecutive cycles, and stk_slot counts up from 0 to 8. The slot codes are 0 PC low, 1 PC high, 2 Y low, 3 Y high, 4 X low, 5 X high, 6 A, 7 B, 8 CCR.
- R5: In the cycle after the CCR push, vec_valid is 1 for one cycle. vec_addr then equals 0xFFFE minus twice take_idx, and mask_i reads 1 from that cycle onward.
- R6: When the CCR is stacked, mask_x is set only if the taken source is index 5. Otherwise mask_x is left unchanged.
- R7: take_idx is the lowest-indexed eligible source, which is the one with the highest vector address. It stays constant for the whole sequence.
- R8: Source 20 is the serial source. It is pending when any of these event/enable pairs is active: ser_ev[0] with ser_en[0], ser_ev[1] with ser_en[1], ser_ev[2] with ser_en[2], ser_ev[3] with ser_en[2], or ser_ev[4] with ser_en[3]. Its vector is 0xFFD6.
- R9: When rti_req and insn_done are both high in an idle cycle, the controller runs a pull sequence from the next cycle. stk_pull is high for nine cycles with stk_slot counting down from 8 to 0, and take stays 0. A return request wins over a pending interrupt.
- R10: A cycle with ccr_wr high loads mask_i from ccr_wdata[0]. mask_x becomes 1 when ccr_wdata[1] is 1 and is never cleared by a write.
- R11: While busy is 1, insn_done and rti_req have no effect. A new take can only follow a cycle in which busy was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag | input | 20 | Request flags of sources 0 to 19 |
| src_en | input | 20 | Local enables of sources 0 to 19 |
| ser_ev | input | 5 | Serial events: tx empty, tx done, rx full, overrun, idle line |
| ser_en | input | 4 | Serial enables: tx empty, tx done, rx full/overrun, idle line |
| ccr_wr | input | 1 | Write strobe for the mask bits |
| ccr_wdata | input | 2 | Written mask value, bit 0 = I, bit 1 = X |
| insn_done | input | 1 | Instruction boundary marker |
| rti_req | input | 1 | The boundary ends a return-from-interrupt |
| mask_i | output | 1 | General interrupt mask bit |
| mask_x | output | 1 | One-way non-maskable-pin mask bit |
| irq_pend | output | 1 | Some source is eligible |
| take | output | 1 | One-cycle interrupt start strobe |
| take_idx | output | 5 | Index of the source being served |
| stk_push | output | 1 | Push one register this cycle |
| stk_pull | output | 1 | Pull one register this cycle |
| stk_slot | output | 4 | Register code of the current push or pull |
| vec_valid | output | 1 | Vector address is valid |
| vec_addr | output | 16 | Vector address of the served source |
| busy | output | 1 | A push or pull sequence is running |

## Verification
A wrong latched winner shows at the ports straight away: take_idx is wrong in the take cycle, and vec_addr is wrong nine cycles later. A stuck or off-by-one step counter changes the length of the stk_push or stk_pull run, or the order of its slot codes, within the nine-cycle window. A wrong mask bit shows one cycle after the CCR push or after a CCR write, on mask_i or mask_x. It also shows as a wrong irq_pend or take at the next instruction boundary. The bench checks every cycle of each sequence against a model of eligibility and priority.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   localparam int NUM_SLOTS = 9;
   localparam int SLOT_W    = 4;

   typedef enum logic [SLOT_W-1:0] {
      SL_PCL = 4'd0, SL_PCH = 4'd1, SL_IYL = 4'd2, SL_IYH = 4'd3,
      SL_IXL = 4'd4, SL_IXH = 4'd5, SL_ACA = 4'd6, SL_ACB = 4'd7,
      SL_CCR = 4'd8
   } stk_slot_e;

   typedef enum logic [1:0] {
      SQ_IDLE, SQ_PUSH, SQ_VEC, SQ_PULL
   } seq_state_e;
endpackage

// File: rtl/ivc_qualify.sv
module ivc_qualify #(
   parameter int NSRC      = 21,
   parameter int FREE_LAST = 4,
   parameter int XPIN_IDX  = 5,
   parameter logic [NSRC-2:0] HAS_EN = '0
) (
   input  logic [NSRC-2:0] flag,
   input  logic [NSRC-2:0] en,
   input  logic [4:0]      ser_ev,
   input  logic [3:0]      ser_en,
   input  logic            mask_i,
   input  logic            mask_x,
   output logic [NSRC-1:0] elig
);
   localparam int NDIRECT = NSRC - 1;

   if (XPIN_IDX <= FREE_LAST || XPIN_IDX >= NDIRECT) begin : g_bad_xpin
      $error("ivc_qualify: pin source index out of range");
   end

   for (genvar k = 0; k < NDIRECT; k++) begin : g_src
      logic loc_ok;
      assign loc_ok = en[k] | ~HAS_EN[k];
      if (k <= FREE_LAST) begin : g_free
         assign elig[k] = flag[k] & loc_ok;
      end else if (k == XPIN_IDX) begin : g_xmask
         assign elig[k] = flag[k] & loc_ok & ~mask_x;
      end else begin : g_imask
         assign elig[k] = flag[k] & loc_ok & ~mask_i;
      end
   end

   logic [4:0] ser_gate;
   assign ser_gate = {ser_en[3], ser_en[2], ser_en[2], ser_en[1], ser_en[0]};
   assign elig[NSRC-1] = (|(ser_ev & ser_gate)) & ~mask_i;
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
   parameter int N        = 21,
   parameter int IDX_W    = 5,
   parameter bit LOW_WINS = 1'b1
) (
   input  logic [N-1:0]     req,
   output logic             valid,
   output logic [IDX_W-1:0] idx
);
   if ((1 << IDX_W) < N) begin : g_bad_w
      $error("ivc_prio: IDX_W too narrow");
   end

   if (LOW_WINS) begin : g_low
      always_comb begin
         valid = 1'b0;
         idx   = '0;
         for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
               valid = 1'b1;
               idx   = IDX_W'(k);
            end
         end
      end
   end else begin : g_high
      always_comb begin
         valid = 1'b0;
         idx   = '0;
         for (int k = 0; k < N; k++) begin
            if (req[k]) begin
               valid = 1'b1;
               idx   = IDX_W'(k);
            end
         end
      end
   end
endmodule

// File: rtl/ivc_seq.sv
module ivc_seq
   import ivc_pkg::*;
#(
   parameter int          IDX_W    = 5,
   parameter logic [15:0] VEC_TOP  = 16'hFFFE,
   parameter int          XPIN_IDX = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_done,
   input  logic              rti_req,
   input  logic              win_valid,
   input  logic [IDX_W-1:0]  win_idx,
   input  logic              ccr_wr,
   input  logic [1:0]        ccr_wdata,
   output logic              mask_i,
   output logic              mask_x,
   output logic              take,
   output logic [IDX_W-1:0]  take_idx,
   output logic              stk_push,
   output logic              stk_pull,
   output logic [SLOT_W-1:0] stk_slot,
   output logic              vec_valid,
   output logic [15:0]       vec_addr,
   output logic              busy
);
   localparam int LAST  = NUM_SLOTS - 1;
   localparam int CNT_W = $clog2(NUM_SLOTS);

   if (NUM_SLOTS > (1 << SLOT_W)) begin : g_bad_slots
      $error("ivc_seq: slot code too narrow");
   end

   seq_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx_q;
   logic             i_q, x_q;
   logic             at_last, stacked;

   assign at_last = (cnt == CNT_W'(LAST));
   assign stacked = (st == SQ_PUSH) && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SQ_IDLE;
         cnt   <= '0;
         idx_q <= '0;
      end else begin
         unique case (st)
            SQ_IDLE: begin
               cnt <= '0;
               if (insn_done && rti_req) begin
                  st <= SQ_PULL;
               end else if (insn_done && win_valid) begin
                  st    <= SQ_PUSH;
                  idx_q <= win_idx;
               end
            end
            SQ_PUSH: begin
               if (at_last) st <= SQ_VEC;
               else         cnt <= cnt + 1'b1;
            end
            SQ_VEC: st <= SQ_IDLE;
            SQ_PULL: begin
               if (at_last) st <= SQ_IDLE;
               else         cnt <= cnt + 1'b1;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i_q <= 1'b1;
         x_q <= 1'b0;
      end else begin
         if (stacked)     i_q <= 1'b1;
         else if (ccr_wr) i_q <= ccr_wdata[0];
         x_q <= x_q | (stacked && idx_q == IDX_W'(XPIN_IDX)) | (ccr_wr & ccr_wdata[1]);
      end
   end

   assign mask_i    = i_q;
   assign mask_x    = x_q;
   assign busy      = (st != SQ_IDLE);
   assign stk_push  = (st == SQ_PUSH);
   assign stk_pull  = (st == SQ_PULL);
   assign take      = stk_push && (cnt == '0);
   assign take_idx  = idx_q;
   assign vec_valid = (st == SQ_VEC);
   assign vec_addr  = VEC_TOP - 16'({idx_q, 1'b0});
   assign stk_slot  = stk_push ? SLOT_W'(cnt) :
                      stk_pull ? SLOT_W'(CNT_W'(LAST) - cnt) : '0;

   AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(insn_done) && !$past(busy)); // R3
   AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      stk_push && stk_slot != SL_CCR |=> stk_push && stk_slot == $past(stk_slot) + 4'd1); // R4
   AST_VEC_AFTER_CCR: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(stk_push) && $past(stk_slot) == SL_CCR); // R5
   AST_I_SET_ON_STACK: assert property (@(posedge clk) disable iff (!rst_n)
      stk_push && stk_slot == SL_CCR |=> mask_i); // R5
   AST_PULL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      stk_pull && stk_slot != SL_PCL |=> stk_pull && stk_slot == $past(stk_slot) - 4'd1); // R9
   AST_X_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      mask_x |=> mask_x); // R10
   AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !take); // R11
   AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !take |-> $stable(take_idx)); // R7
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import ivc_pkg::*;
#(
   parameter int          NSRC      = 21,
   parameter int          IDX_W     = $clog2(NSRC),
   parameter logic [15:0] VEC_TOP   = 16'hFFFE,
   parameter logic [15:0] VEC_FLOOR = 16'hFFD6,
   parameter int          FREE_LAST = 4,
   parameter int          XPIN_IDX  = 5,
   parameter logic [NSRC-2:0] HAS_EN = 20'hFFF82
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-2:0]   src_flag,
   input  logic [NSRC-2:0]   src_en,
   input  logic [4:0]        ser_ev,
   input  logic [3:0]        ser_en,
   input  logic              ccr_wr,
   input  logic [1:0]        ccr_wdata,
   input  logic              insn_done,
   input  logic              rti_req,
   output logic              mask_i,
   output logic              mask_x,
   output logic              irq_pend,
   output logic              take,
   output logic [IDX_W-1:0]  take_idx,
   output logic              stk_push,
   output logic              stk_pull,
   output logic [SLOT_W-1:0] stk_slot,
   output logic              vec_valid,
   output logic [15:0]       vec_addr,
   output logic              busy
);
   if (NSRC > 32 || NSRC < XPIN_IDX + 2) begin : g_bad_nsrc
      $error("irq_vector_ctrl: NSRC out of range");
   end
   if (IDX_W != $clog2(NSRC)) begin : g_bad_idxw
      $error("irq_vector_ctrl: IDX_W must match NSRC");
   end
   if (int'(VEC_TOP) - 2 * (NSRC - 1) < int'(VEC_FLOOR)) begin : g_bad_vec
      $error("irq_vector_ctrl: vectors run into the reserved range");
   end

   logic [NSRC-1:0]  elig;
   logic             win_valid;
   logic [IDX_W-1:0] win_idx;

   ivc_qualify #(
      .NSRC(NSRC), .FREE_LAST(FREE_LAST), .XPIN_IDX(XPIN_IDX), .HAS_EN(HAS_EN)
   ) u_qual (
      .flag(src_flag), .en(src_en), .ser_ev(ser_ev), .ser_en(ser_en),
      .mask_i(mask_i), .mask_x(mask_x), .elig(elig)
   );

   ivc_prio #(.N(NSRC), .IDX_W(IDX_W), .LOW_WINS(1'b1)) u_prio (
      .req(elig), .valid(win_valid), .idx(win_idx)
   );

   ivc_seq #(.IDX_W(IDX_W), .VEC_TOP(VEC_TOP), .XPIN_IDX(XPIN_IDX)) u_seq (
      .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .rti_req(rti_req),
      .win_valid(win_valid), .win_idx(win_idx),
      .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
      .mask_i(mask_i), .mask_x(mask_x), .take(take), .take_idx(take_idx),
      .stk_push(stk_push), .stk_pull(stk_pull), .stk_slot(stk_slot),
      .vec_valid(vec_valid), .vec_addr(vec_addr), .busy(busy)
   );

   assign irq_pend = win_valid;

   AST_MASKED_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !(int'(take_idx) > XPIN_IDX && $past(mask_i))); // R2
   AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> vec_addr >= VEC_FLOOR && !vec_addr[0]); // R5
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] src_flag = '0, src_en = '0;
   logic [4:0]  ser_ev = '0;
   logic [3:0]  ser_en = '0;
   logic        ccr_wr = 1'b0;
   logic [1:0]  ccr_wdata = '0;
   logic        insn_done = 1'b0, rti_req = 1'b0;
   logic        mask_i, mask_x, irq_pend, take, stk_push, stk_pull, vec_valid, busy;
   logic [4:0]  take_idx;
   logic [3:0]  stk_slot;
   logic [15:0] vec_addr;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic m_i = 1'b1, m_x = 1'b0;

   always #5 clk = ~clk;

   irq_vector_ctrl u_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
      .ser_ev(ser_ev), .ser_en(ser_en), .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
      .insn_done(insn_done), .rti_req(rti_req), .mask_i(mask_i), .mask_x(mask_x),
      .irq_pend(irq_pend), .take(take), .take_idx(take_idx), .stk_push(stk_push),
      .stk_pull(stk_pull), .stk_slot(stk_slot), .vec_valid(vec_valid),
      .vec_addr(vec_addr), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic bit has_en(input int k);
      return (k == 1) || (k >= 7);
   endfunction

   function automatic int model_win();
      for (int k = 0; k < 20; k++) begin
         bit ok;
         ok = src_flag[k] && (!has_en(k) || src_en[k]);
         if (k == 5) ok = ok && !m_x;
         else if (k > 5) ok = ok && !m_i;
         if (ok) return k;
      end
      if (((ser_ev[0] & ser_en[0]) | (ser_ev[1] & ser_en[1]) | (ser_ev[2] & ser_en[2]) |
           (ser_ev[3] & ser_en[2]) | (ser_ev[4] & ser_en[3])) && !m_i) return 20;
      return 31;
   endfunction

   task automatic ccr_write(input logic wi, input logic wx);
      @(negedge clk);
      ccr_wr = 1'b1; ccr_wdata = {wx, wi};
      @(negedge clk);
      ccr_wr = 1'b0;
      m_i = wi; m_x = m_x | wx;
      chk(mask_i == m_i, "R10 mask_i", mask_i, m_i);
      chk(mask_x == m_x, "R10 mask_x", mask_x, m_x);
   endtask

   task automatic run_take(input bit hold);
      int exp;
      #1;
      exp = model_win();
      chk(irq_pend == (exp != 31), "R2 irq_pend", irq_pend, exp != 31);
      insn_done = 1'b1;
      @(negedge clk);
      insn_done = hold;
      if (exp == 31) begin
         chk(!take && !busy, "R2 no take", take, 0);
         insn_done = 1'b0;
         return;
      end
      chk(take, "R3 take", take, 1);
      chk(int'(take_idx) == exp, "R7 take_idx", take_idx, exp);
      chk(stk_push && stk_slot == 0, "R4 slot", stk_slot, 0);
      for (int s = 1; s < 9; s++) begin
         @(negedge clk);
         chk(stk_push && int'(stk_slot) == s, "R4 slot", stk_slot, s);
         chk(!take, "R11 single take", take, 0);
      end
      @(negedge clk);
      if (exp == 5) m_x = 1'b1;
      m_i = 1'b1;
      chk(vec_valid && int'(vec_addr) == 16'hFFFE - 2 * exp, "R5 vec_addr", vec_addr, 16'hFFFE - 2 * exp);
      chk(mask_i == 1'b1, "R5 mask_i", mask_i, 1);
      chk(mask_x == m_x, "R6 mask_x", mask_x, m_x);
      insn_done = 1'b0;
      @(negedge clk);
      chk(!busy && !vec_valid && !take, "R11 end", busy, 0);
   endtask

   task automatic run_rti();
      rti_req = 1'b1; insn_done = 1'b1;
      @(negedge clk);
      rti_req = 1'b0; insn_done = 1'b0;
      chk(!take && stk_pull && stk_slot == 8, "R9 pull start", stk_slot, 8);
      for (int s = 7; s >= 0; s--) begin
         @(negedge clk);
         chk(stk_pull && !stk_push && int'(stk_slot) == s, "R9 pull slot", stk_slot, s);
      end
      @(negedge clk);
      chk(!busy && !stk_pull && !take, "R9 pull end", busy, 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mask_i == 1'b1 && mask_x == 1'b0, "R1 masks", {mask_x, mask_i}, 2'b01);
      chk(!take && !busy && !stk_push && !stk_pull && !vec_valid, "R1 idle", busy, 0);

      // R3: pending source waits for a boundary
      ccr_write(1'b0, 1'b0);
      src_flag = 20'h1 << 8; src_en = 20'h1 << 8;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         chk(!take && !busy, "R3 waits for boundary", take, 0);
      end
      run_take(1'b0);
      // R2: masked by I after the take
      run_take(1'b0);
      ccr_write(1'b0, 1'b0);
      // R7: priority between sources
      src_flag = (20'h1 << 6) | (20'h1 << 12); src_en = '1;
      run_take(1'b0);
      ccr_write(1'b0, 1'b0);
      src_flag = 20'h1 << 19; ser_ev = 5'h1; ser_en = 4'h1;
      run_take(1'b0);
      ccr_write(1'b0, 1'b0);
      // R8: each serial event with and without its enable
      src_flag = '0;
      for (int e = 0; e < 5; e++) begin
         int en_bit;
         en_bit = (e < 3) ? e : e - 1;
         ser_ev = 5'(1 << e);
         ser_en = ~4'(1 << en_bit);
         run_take(1'b0);
         ser_en = 4'(1 << en_bit);
         run_take(1'b0);
         ccr_write(1'b0, 1'b0);
      end
      ser_ev = '0;
      // R2: local enables
      src_flag = 20'h1 << 7; src_en = '0;
      run_take(1'b0);
      src_flag = 20'h1 << 3;
      run_take(1'b1);      // R11: insn_done held during the sequence
      ccr_write(1'b0, 1'b0);
      // R9: return wins over a pending source
      src_flag = 20'h1 << 9; src_en = '1;
      run_rti();
      // R6 / R10: pin source sets X, software cannot clear it
      src_flag = 20'h1 << 5;
      run_take(1'b0);
      ccr_write(1'b0, 1'b0);
      run_take(1'b0);
      // random phase
      for (int it = 0; it < 300; it++) begin
         ccr_write(($urandom % 4) == 0, 1'b0);
         src_flag = ($urandom % 5 == 0) ? '0 : 20'($urandom & $urandom & $urandom);
         src_en = 20'($urandom);
         ser_ev = 5'($urandom & $urandom);
         ser_en = 4'($urandom);
         if ($urandom % 6 == 0) run_rti();
         else run_take(($urandom % 2) == 1);
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule